// File: doc/BRIEF.md
# Packed Saturating SIMD Adder

This block adds or subtracts two 64-bit operands as a set of independent packed integer lanes. A lane-size select splits each operand into eight 8-bit lanes, four 16-bit lanes or two 32-bit lanes. Every lane is computed at the same time, and no carry or borrow ever crosses from one lane into the next.

For each operation, a mode select picks how a lane handles a result that does not fit. Wraparound mode keeps the low bits of the result. Unsigned saturation clamps the lane to its largest or smallest unsigned value. Signed saturation clamps the lane to its largest or smallest two's-complement value. Saturation is available for 8-bit and 16-bit lanes only. A saturation request with 32-bit lanes produces wraparound results.

The inputs are taken when an input strobe is high. The result is registered and appears one clock later, together with a valid flag. Between strobes, the output register holds its last value.

Top module: `simd_addsat`

## Requirements
- R1: A synchronous active-high reset clears `res` to zero and `res_valid` to 0 on the next rising edge.
- R2: `res_valid` is high in the cycle after a cycle in which `in_valid` was high, and low otherwise. The result of the operands sampled with `in_valid` appears on `res` in that same following cycle.
- R3: While `in_valid` is low, `res` keeps its previous value.
- R4: In wraparound mode (`mode_sel` 0), each lane keeps only its low bits. Carries and borrows are dropped at every lane boundary. For example, the byte A0h+70h gives 10h, and a carry out of byte 0 does not change byte 1.
- R5: In unsigned saturation mode (`mode_sel` 1), an add that carries out of a lane gives all ones for that lane. A subtract that borrows gives all zeros for that lane.
- R6: In signed saturation mode (`mode_sel` 2), a lane that overflows gives the largest positive value (7F..F). A lane that underflows gives the most negative value (80..0). Overflow means the operands of an add have the same sign, or the operands of a subtract have different signs, and the result sign differs from the sign of operand A.
- R7: With 16-bit lanes, FFFFh plus 8000h gives 7FFFh in wraparound mode, FFFFh in unsigned saturation mode and 8000h in signed saturation mode.
- R8: With 8-bit lanes and signed saturation, 8080555580805555h plus 009033FF009033FFh gives 80807F5480807F54h.
- R9: With 32-bit lanes (`lane_sel` 2 or 3), every mode produces wraparound results.
- R10: `lane_sel` 0 selects 8-bit lanes, 1 selects 16-bit lanes, and 2 or 3 selects 32-bit lanes. `sub_sel` 1 computes A minus B and 0 computes A plus B. `mode_sel` 3 behaves as wraparound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input strobe; operands are taken when high |
| op_a | input | 64 | Operand A (minuend for subtract) |
| op_b | input | 64 | Operand B |
| lane_sel | input | 2 | Lane size: 0 = 8-bit, 1 = 16-bit, 2/3 = 32-bit |
| sub_sel | input | 1 | 1 = subtract, 0 = add |
| mode_sel | input | 2 | 0/3 = wraparound, 1 = unsigned saturate, 2 = signed saturate |
| res | output | 64 | Registered packed result |
| res_valid | output | 1 | High for one cycle per accepted operation |

## Verification
The block holds almost no state, so an internal fault shows up on `res` in the very next cycle after a strobe. A carry that leaks across a lane boundary corrupts only the lane above it. The vectors therefore put a carry or borrow at a lane edge and check the neighbouring lane. A wrong overflow decision looks like a correct wraparound result in the wrong mode, or a clamp where none belongs. For this reason the same operands are run in every mode, and cases that just miss overflow are included. A broken output register shows up either as a change on `res` while the strobe is low, or as a valid flag that is off by one cycle.

// File: rtl/simd_pkg.sv
package simd_pkg;
  typedef enum logic [1:0] {
    LANE_8  = 2'd0,
    LANE_16 = 2'd1,
    LANE_32 = 2'd2,
    LANE_32B = 2'd3
  } lane_e;

  typedef enum logic [1:0] {
    MODE_WRAP  = 2'd0,
    MODE_USAT  = 2'd1,
    MODE_SSAT  = 2'd2,
    MODE_WRAPB = 2'd3
  } mode_e;
endpackage

// File: rtl/lane_addsat.sv
module lane_addsat
  import simd_pkg::*;
#(
  parameter int W = 8,
  parameter bit SAT_OK = 1'b1
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  mode_e        mode,
  output logic [W-1:0] y
);
  localparam logic [W-1:0] UMAX = '1;
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] b_eff;
  logic [W:0]   full;
  logic [W-1:0] sum;
  logic         carry, u_ovf, s_ovf;

  assign b_eff = sub ? ~b : b;
  assign full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
  assign sum   = full[W-1:0];
  assign carry = full[W];
  // add: carry out means overflow; subtract: missing carry means borrow
  assign u_ovf = sub ? ~carry : carry;
  assign s_ovf = (sub ? (a[W-1] != b[W-1]) : (a[W-1] == b[W-1]))
                 && (sum[W-1] != a[W-1]);

  generate
    if (SAT_OK) begin : g_sat
      always_comb begin
        y = sum;
        case (mode)
          MODE_USAT: if (u_ovf) y = sub ? '0 : UMAX;
          MODE_SSAT: if (s_ovf) y = a[W-1] ? SMIN : SMAX;
          default:   y = sum;
        endcase
      end
    end else begin : g_wrap
      logic unused_sat;
      assign unused_sat = ^{mode, u_ovf, s_ovf};
      assign y = sum;
    end
  endgenerate
endmodule

// File: rtl/simd_addsat.sv
module simd_addsat
  import simd_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [1:0]        lane_sel,
  input  logic              sub_sel,
  input  logic [1:0]        mode_sel,
  output logic [DATA_W-1:0] res,
  output logic              res_valid
);
  localparam int N8  = DATA_W / 8;
  localparam int N16 = DATA_W / 16;
  localparam int N32 = DATA_W / 32;

  mode_e mode;
  assign mode = mode_e'(mode_sel);

  logic [DATA_W-1:0] r8, r16, r32, nxt;

  genvar i;
  generate
    for (i = 0; i < N8; i++) begin : g_b
      lane_addsat #(.W(8), .SAT_OK(1'b1)) u_l (
        .a(op_a[i*8 +: 8]), .b(op_b[i*8 +: 8]),
        .sub(sub_sel), .mode(mode), .y(r8[i*8 +: 8]));
    end
    for (i = 0; i < N16; i++) begin : g_w
      lane_addsat #(.W(16), .SAT_OK(1'b1)) u_l (
        .a(op_a[i*16 +: 16]), .b(op_b[i*16 +: 16]),
        .sub(sub_sel), .mode(mode), .y(r16[i*16 +: 16]));
    end
    for (i = 0; i < N32; i++) begin : g_d
      lane_addsat #(.W(32), .SAT_OK(1'b0)) u_l (
        .a(op_a[i*32 +: 32]), .b(op_b[i*32 +: 32]),
        .sub(sub_sel), .mode(mode), .y(r32[i*32 +: 32]));
    end
  endgenerate

  always_comb begin
    case (lane_e'(lane_sel))
      LANE_8:  nxt = r8;
      LANE_16: nxt = r16;
      default: nxt = r32;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res       <= '0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= in_valid;
      if (in_valid) res <= nxt;
    end
  end
endmodule

// File: rtl/simd_addsat_chk.sv
module simd_addsat_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [DATA_W-1:0] op_a,
  input logic [DATA_W-1:0] op_b,
  input logic [1:0]        lane_sel,
  input logic              sub_sel,
  input logic [1:0]        mode_sel,
  input logic [DATA_W-1:0] res,
  input logic              res_valid
);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (res == '0) && !res_valid);

  a_r2_valid_set: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> res_valid);

  a_r2_valid_clr: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !res_valid);

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(res));

  a_r4_wrap_byte0: assert property (@(posedge clk) disable iff (rst)
    (in_valid && lane_sel == 2'd0 && mode_sel == 2'd0 && !sub_sel)
    |=> res[7:0] == $past(op_a[7:0] + op_b[7:0]));

  a_r9_dword_add: assert property (@(posedge clk) disable iff (rst)
    (in_valid && lane_sel[1] && !sub_sel)
    |=> res[31:0] == $past(op_a[31:0] + op_b[31:0]));

  a_r9_dword_sub: assert property (@(posedge clk) disable iff (rst)
    (in_valid && lane_sel[1] && sub_sel)
    |=> res[31:0] == $past(op_a[31:0] - op_b[31:0]));
endmodule

bind simd_addsat simd_addsat_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/test_simd_addsat.sv
`timescale 1ns/1ps
module test_simd_addsat;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] op_a = '0, op_b = '0;
  logic [1:0]  lane_sel = '0;
  logic        sub_sel = 1'b0;
  logic [1:0]  mode_sel = '0;
  logic [63:0] res;
  logic        res_valid;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  simd_addsat i_simd_addsat (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .lane_sel(lane_sel), .sub_sel(sub_sel), .mode_sel(mode_sel),
    .res(res), .res_valid(res_valid));

  typedef struct packed {
    logic [31:0] tag;
    logic [1:0]  lane;
    logic        sub;
    logic [1:0]  mode;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] exp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    // R4: byte wrap, A0+70=10, carry from byte0 not into byte1
    '{"R4  ", 2'd0, 1'b0, 2'd0, 64'h0000_0000_0000_FFA0, 64'h0000_0000_0000_0170, 64'h0000_0000_0000_0010},
    // R7: word lanes, three modes
    '{"R7  ", 2'd1, 1'b0, 2'd0, 64'h0000_0000_0000_FFFF, 64'h0000_0000_0000_8000, 64'h0000_0000_0000_7FFF},
    '{"R7  ", 2'd1, 1'b0, 2'd1, 64'h0000_0000_0000_FFFF, 64'h0000_0000_0000_8000, 64'h0000_0000_0000_FFFF},
    '{"R7  ", 2'd1, 1'b0, 2'd2, 64'h0000_0000_0000_FFFF, 64'h0000_0000_0000_8000, 64'h0000_0000_0000_8000},
    // R8: signed byte saturating add
    '{"R8  ", 2'd0, 1'b0, 2'd2, 64'h8080_5555_8080_5555, 64'h0090_33FF_0090_33FF, 64'h8080_7F54_8080_7F54},
    // R5: unsigned byte subtract, borrow clamps to zero
    '{"R5  ", 2'd0, 1'b1, 2'd1, 64'h0000_0000_0000_1005, 64'h0000_0000_0000_0510, 64'h0000_0000_0000_0B00},
    // R6: signed word subtract, under/overflow and a normal lane
    '{"R6  ", 2'd1, 1'b1, 2'd2, 64'h0000_0005_7FFF_8000, 64'h0000_0003_FFFF_0001, 64'h0000_0002_7FFF_8000},
    // R9: dword with signed saturation request wraps
    '{"R9  ", 2'd2, 1'b0, 2'd2, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0001, 64'h8000_0000_0000_0000},
    // R9/R10: lane_sel 3 is dword, unsigned request wraps on subtract
    '{"R9  ", 2'd3, 1'b1, 2'd1, 64'h0000_0000_0000_0000, 64'h0000_0001_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF},
    // R5: unsigned word add clamps to all ones
    '{"R5  ", 2'd1, 1'b0, 2'd1, 64'hFFF0_0001_0000_0000, 64'h0020_0002_0000_0000, 64'hFFFF_0003_0000_0000},
    // R10: mode 3 behaves as wraparound
    '{"R10 ", 2'd0, 1'b0, 2'd3, 64'h0000_0000_0000_00FF, 64'h0000_0000_0000_0002, 64'h0000_0000_0000_0001},
    // R6: signed byte add, positive and negative overflow
    '{"R6  ", 2'd0, 1'b0, 2'd2, 64'h0000_0000_0000_807F, 64'h0000_0000_0000_FF01, 64'h0000_0000_0000_807F}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    op_a = v.a; op_b = v.b; lane_sel = v.lane; sub_sel = v.sub;
    mode_sel = v.mode; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin : watchdog
    #(4 * 20000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [63:0] held;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", res, 64'h0);
    check("R1", {63'h0, res_valid}, 64'h0);
    rst = 1'b0;

    for (int k = 0; k < NV; k++) begin
      apply(VEC[k]);
      check($sformatf("%s", VEC[k].tag), res, VEC[k].exp);
      check("R2", {63'h0, res_valid}, 64'h1);
    end

    // R3: result holds while strobe is low, valid drops (R2)
    held = res;
    op_a = 64'h1111_1111_1111_1111; op_b = 64'h2222_2222_2222_2222;
    repeat (3) @(negedge clk);
    check("R3", res, held);
    check("R2", {63'h0, res_valid}, 64'h0);

    // R4: word wrap subtract, borrow does not cross into upper word
    apply('{"R4  ", 2'd1, 1'b1, 2'd0, 64'h0000_0000_0005_0000, 64'h0000_0000_0000_0001, 64'h0000_0000_0005_FFFF});
    check("R4", res, 64'h0000_0000_0005_FFFF);

    // R1: reset clears result mid-run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1", res, 64'h0);
    check("R1", {63'h0, res_valid}, 64'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule